// File: doc/BRIEF.md
# Collapsed-Prefix CAM Lookup Unit

This unit is one stage of an IP longest-prefix-match engine. It stores up to `DEPTH` collapsed prefixes, all of the same length `CP_W`, in a binary content-addressable array. Each slot has a companion memory row that holds a stride tree bitmap of `2^(STRIDE_W+1)-1` bits and a next-hop base index. A lookup takes a destination address and splits it into a leading key of `CP_W` bits and the `STRIDE_W` bits that follow. The key is compared exactly against every live slot. The lowest matching slot number then reads its companion row. The bitmap, the base and the stride bits go on to a downstream stride matcher, which finishes the prefix match.

Lookups enter and results leave over valid/ready handshakes. An address is taken on a clock edge where `lk_valid` and `lk_ready` are both high. A result is consumed on an edge where `res_valid` and `res_ready` are both high. While `res_valid` is high and `res_ready` is low, the result registers hold their values. The compare stage then fills and stops, and `lk_ready` drops once both stages are occupied. Table updates arrive on a plain write port that has no handshake.

Top module: `cpcam_lookup`

## Requirements
- R1: The key is `lk_addr[31:16]` and the stride is `lk_addr[15:13]` (default parameters). `res_stride` returns those three bits for every lookup, hit or miss.
- R2: `res_hit` is 1 only when a live slot holds a key equal to the address key in all 16 bits. On a miss, `res_idx`, `res_bitmap` and `res_base` are all zero.
- R3: When several live slots hold the same key, `res_idx` is the lowest of their slot numbers.
- R4: On a hit, `res_bitmap` (15 bits) and `res_base` (16 bits) are the values last stored in the row of the slot reported in `res_idx`.
- R5: A write with `tw_en=1` and `tw_live=1` stores the key, bitmap and base at slot `tw_slot` and makes the slot live. With `tw_live=0`, the slot stops taking part in compares and its row keeps its earlier bitmap and base.
- R6: A lookup accepted on the same edge as a write is compared against the table as it stood before that write.
- R7: With `res_ready` held high, a lookup accepted on clock edge k produces `res_valid=1` after edge k+1.
- R8: While `res_valid=1` and `res_ready=0`, every result output holds its value. No accepted lookup is dropped or repeated, and results leave in the order their lookups were accepted.
- R9: After reset all slots are empty, `res_valid=0` and `lk_ready=1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tw_en | input | 1 | Table write strobe |
| tw_slot | input | 4 | Slot number to write |
| tw_key | input | 16 | Collapsed prefix to store |
| tw_bitmap | input | 15 | Stride tree bitmap for the row |
| tw_base | input | 16 | Next-hop base index for the row |
| tw_live | input | 1 | 1 stores and makes the slot live, 0 empties the slot |
| lk_valid | input | 1 | Lookup address present |
| lk_ready | output | 1 | Unit can take a lookup this edge |
| lk_addr | input | 32 | Destination address |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Downstream takes the result this edge |
| res_hit | output | 1 | Key matched a live slot |
| res_idx | output | 4 | Lowest matching slot |
| res_bitmap | output | 15 | Stride tree bitmap of that slot |
| res_base | output | 16 | Next-hop base of that slot |
| res_stride | output | 3 | Stride bits of the address |

## Verification
The hardest case to reach is a write and a lookup that land on the same edge and touch the same key. The stimulus drives this case twice with `res_ready` held high, so the lookup is certain to be accepted on the write's edge. In the first run, a new key is written while the same key is looked up, and the result must be a miss. In the second run, a slot is emptied while its key is looked up, and the result must still be a hit that returns the old row. A follow-up lookup after each run shows the new table state. Duplicate keys are made by writing one key into two slots, so the lowest-slot rule can be seen. Then the lower slot is emptied, and the higher slot must take over. Random stalls on `res_ready` during a burst of lookups test the holding and ordering rules.

// File: rtl/cpcam_pkg.sv
package cpcam_pkg;
  // Node count of a full binary tree over a stride of s bits: 2^(s+1)-1
  function automatic int tree_bits(int s);
    return (1 << (s + 1)) - 1;
  endfunction
endpackage

// File: rtl/cpcam_match_array.sv
module cpcam_match_array #(
  parameter int DEPTH = 16,
  parameter int CP_W  = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [CP_W-1:0]  wr_key,
  input  logic             wr_live,
  input  logic [CP_W-1:0]  key,
  output logic [DEPTH-1:0] hit_vec,
  output logic [DEPTH-1:0] live_vec
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic            live_q;
    logic [CP_W-1:0] key_q;
    logic            sel;
    assign sel = wr_en && (wr_slot == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   live_q <= 1'b0;
      else if (sel) live_q <= wr_live;
    end

    always_ff @(posedge clk) begin
      if (sel && wr_live) key_q <= wr_key;
    end

    assign hit_vec[g]  = live_q && (key_q == key);
    assign live_vec[g] = live_q;
  end

  // R5
  empty_after_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_live) |=> !live_vec[$past(wr_slot)]);
  // R5
  live_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_live) |=> live_vec[$past(wr_slot)]);
endmodule

// File: rtl/cpcam_low_enc.sv
module cpcam_low_enc #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R3
  enc_points_at_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]);
  // R3
  enc_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req & ((DEPTH'(1) << idx) - DEPTH'(1))) == '0));
  // R2
  enc_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (req == '0));
endmodule

// File: rtl/cpcam_row_mem.sv
module cpcam_row_mem #(
  parameter int DEPTH  = 16,
  parameter int BMP_W  = 15,
  parameter int BASE_W = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [BMP_W-1:0]  wr_bmp,
  input  logic [BASE_W-1:0] wr_base,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_slot,
  output logic [BMP_W-1:0]  rd_bmp,
  output logic [BASE_W-1:0] rd_base
);
  logic [BMP_W-1:0]  bmp_mem  [DEPTH];
  logic [BASE_W-1:0] base_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      bmp_mem[wr_slot]  <= wr_bmp;
      base_mem[wr_slot] <= wr_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bmp  <= '0;
      rd_base <= '0;
    end else if (rd_en) begin
      rd_bmp  <= bmp_mem[rd_slot];
      rd_base <= base_mem[rd_slot];
    end
  end
endmodule

// File: rtl/cpcam_lookup.sv
module cpcam_lookup #(
  parameter int ADDR_W   = 32,
  parameter int CP_W     = 16,
  parameter int STRIDE_W = 3,
  parameter int DEPTH    = 16,
  parameter int BASE_W   = 16,
  parameter int IDX_W    = $clog2(DEPTH),
  parameter int BMP_W    = cpcam_pkg::tree_bits(STRIDE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tw_en,
  input  logic [IDX_W-1:0]    tw_slot,
  input  logic [CP_W-1:0]     tw_key,
  input  logic [BMP_W-1:0]    tw_bitmap,
  input  logic [BASE_W-1:0]   tw_base,
  input  logic                tw_live,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [ADDR_W-1:0]   lk_addr,
  output logic                res_valid,
  input  logic                res_ready,
  output logic                res_hit,
  output logic [IDX_W-1:0]    res_idx,
  output logic [BMP_W-1:0]    res_bitmap,
  output logic [BASE_W-1:0]   res_base,
  output logic [STRIDE_W-1:0] res_stride
);
  localparam int LOW_W = ADDR_W - CP_W - STRIDE_W;

  logic [CP_W-1:0]     key;
  logic [STRIDE_W-1:0] stride_in;
  logic                unused_low;
  assign key        = lk_addr[ADDR_W-1 -: CP_W];
  assign stride_in  = lk_addr[ADDR_W-CP_W-1 -: STRIDE_W];
  assign unused_low = ^lk_addr[LOW_W-1:0];

  logic [DEPTH-1:0] hit_vec, live_vec;
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;

  cpcam_match_array #(.DEPTH(DEPTH), .CP_W(CP_W), .IDX_W(IDX_W)) match_i (
    .clk(clk), .rst_n(rst_n), .wr_en(tw_en), .wr_slot(tw_slot), .wr_key(tw_key),
    .wr_live(tw_live), .key(key), .hit_vec(hit_vec), .live_vec(live_vec));

  cpcam_low_enc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) enc_i (
    .clk(clk), .rst_n(rst_n), .req(hit_vec), .any(any_hit), .idx(hit_idx));

  // Stage 1: compare result; stage 2: row read and result registers
  logic                s1_v, s1_hit;
  logic [IDX_W-1:0]    s1_idx;
  logic [STRIDE_W-1:0] s1_stride;
  logic                s2_v, s2_hit;
  logic [IDX_W-1:0]    s2_idx;
  logic [STRIDE_W-1:0] s2_stride;
  logic                adv, s1_take;

  assign adv      = !s2_v || res_ready;
  assign s1_take  = !s1_v || adv;
  assign lk_ready = s1_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_hit    <= 1'b0;
      s1_idx    <= '0;
      s1_stride <= '0;
    end else if (s1_take) begin
      s1_v      <= lk_valid;
      s1_hit    <= any_hit;
      s1_idx    <= hit_idx;
      s1_stride <= stride_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v      <= 1'b0;
      s2_hit    <= 1'b0;
      s2_idx    <= '0;
      s2_stride <= '0;
    end else if (adv) begin
      s2_v      <= s1_v;
      s2_hit    <= s1_v && s1_hit;
      s2_idx    <= s1_hit ? s1_idx : '0;
      s2_stride <= s1_stride;
    end
  end

  logic [BMP_W-1:0]  row_bmp;
  logic [BASE_W-1:0] row_base;

  cpcam_row_mem #(.DEPTH(DEPTH), .BMP_W(BMP_W), .BASE_W(BASE_W), .IDX_W(IDX_W)) rows_i (
    .clk(clk), .rst_n(rst_n), .wr_en(tw_en && tw_live), .wr_slot(tw_slot),
    .wr_bmp(tw_bitmap), .wr_base(tw_base), .rd_en(adv && s1_v && s1_hit),
    .rd_slot(s1_idx), .rd_bmp(row_bmp), .rd_base(row_base));

  assign res_valid  = s2_v;
  assign res_hit    = s2_hit;
  assign res_idx    = s2_idx;
  assign res_bitmap = s2_hit ? row_bmp  : '0;
  assign res_base   = s2_hit ? row_base : '0;
  assign res_stride = s2_stride;

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_idx)
      && $stable(res_bitmap) && $stable(res_base) && $stable(res_stride)));
  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_idx == '0 && res_bitmap == '0 && res_base == '0));
  // R7
  res_from_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(s1_v));
  // R2
  hit_slot_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_take && lk_valid && any_hit) |-> live_vec[hit_idx]);
  // R9
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1_v && !s2_v) |-> lk_ready);
endmodule

// File: tb/cpcam_lookup_tb_top.sv
module cpcam_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tw_en = 1'b0;
  logic [3:0]  tw_slot = '0;
  logic [15:0] tw_key = '0;
  logic [14:0] tw_bitmap = '0;
  logic [15:0] tw_base = '0;
  logic        tw_live = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [3:0]  res_idx;
  logic [14:0] res_bitmap;
  logic [15:0] res_base;
  logic [2:0]  res_stride;

  always #5 clk = ~clk;

  cpcam_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .tw_en(tw_en), .tw_slot(tw_slot), .tw_key(tw_key),
    .tw_bitmap(tw_bitmap), .tw_base(tw_base), .tw_live(tw_live),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_idx(res_idx),
    .res_bitmap(res_bitmap), .res_base(res_base), .res_stride(res_stride));

  typedef struct {
    logic [38:0] v;
    int          t;
    bit          timed;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit bp_on = 1'b0;

  bit          m_live [16];
  logic [15:0] m_key  [16];
  logic [14:0] m_bmp  [16];
  logic [15:0] m_base [16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    res_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [38:0] predict(logic [31:0] a);
    logic [38:0] r;
    bit found;
    found = 1'b0;
    r = {1'b0, 4'd0, 15'd0, 16'd0, a[15:13]};
    for (int i = 0; i < 16; i++) begin
      if (!found && m_live[i] && m_key[i] == a[31:16]) begin
        found = 1'b1;
        r = {1'b1, 4'(i), m_bmp[i], m_base[i], a[15:13]};
      end
    end
    return r;
  endfunction

  // Monitor: compare each consumed result against the scoreboard
  logic [38:0] held_v;
  bit          held = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held)
        check({res_valid, res_hit, res_idx, res_bitmap, res_base, res_stride} == {1'b1, held_v},
              "R8 hold", 64'({res_hit, res_idx, res_bitmap, res_base, res_stride}), 64'(held_v));
      held   = res_valid && !res_ready;
      held_v = {res_hit, res_idx, res_bitmap, res_base, res_stride};
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 extra result", 64'(held_v), 64'd0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(held_v == it.v, it.tag, 64'(held_v), 64'(it.v));
          if (it.timed) check(cyc - it.t == 1, "R7 latency", 64'(cyc - it.t), 64'd1);
        end
      end
    end
  end

  task automatic push(logic [31:0] a, string tag, logic [38:0] e);
    item_t it;
    it.v = e; it.t = cyc; it.timed = !bp_on; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic accept_wait();
    bit rdy;
    forever begin
      @(negedge clk); rdy = lk_ready;
      @(posedge clk);
      if (rdy) break;
    end
    #1;
  endtask

  task automatic lookup(logic [31:0] a, string tag);
    @(posedge clk); #1;
    lk_valid = 1'b1; lk_addr = a;
    accept_wait();
    push(a, tag, predict(a));
    lk_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic twrite(int s, logic [15:0] k, logic [14:0] b, logic [15:0] bs, bit live);
    if (live) drain();
    @(posedge clk); #1;
    tw_en = 1'b1; tw_slot = 4'(s); tw_key = k; tw_bitmap = b; tw_base = bs; tw_live = live;
    @(posedge clk); #1;
    tw_en = 1'b0;
    m_live[s] = live;
    if (live) begin m_key[s] = k; m_bmp[s] = b; m_base[s] = bs; end
  endtask

  // Lookup and write on the same edge (back-pressure off, so accepted at once)
  task automatic lookup_with_write(logic [31:0] a, int s, logic [15:0] k, logic [14:0] b,
                                   logic [15:0] bs, bit live, string tag);
    logic [38:0] e;
    drain();
    @(posedge clk); #1;
    e = predict(a);
    lk_valid = 1'b1; lk_addr = a;
    tw_en = 1'b1; tw_slot = 4'(s); tw_key = k; tw_bitmap = b; tw_base = bs; tw_live = live;
    @(posedge clk); #1;
    tw_en = 1'b0; lk_valid = 1'b0;
    push(a, tag, e);
    m_live[s] = live;
    if (live) begin m_key[s] = k; m_bmp[s] = b; m_base[s] = bs; end
  endtask

  function automatic logic [15:0] key_of(int k);
    return 16'hA000 + 16'(k * 16'h0111);
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) m_live[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(res_valid == 1'b0, "R9 res_valid after reset", 64'(res_valid), 64'd0);
    check(lk_ready == 1'b1, "R9 lk_ready after reset", 64'(lk_ready), 64'd1);
    lookup({key_of(0), 3'd5, 13'h0}, "R9 empty table misses");

    // R5 R4 store six slots, then hit each with differing strides (R1)
    for (int s = 0; s < 6; s++)
      twrite(s, key_of(s), 15'(16'h1234 * (s + 1)), 16'(16'h0100 + s * 7), 1'b1);
    for (int s = 0; s < 6; s++)
      lookup({key_of(s), 3'(s + 1), 13'(s * 77)}, "R4 hit row data");
    // R2 near-miss keys differ in one bit only
    lookup({key_of(2) ^ 16'h0001, 3'd7, 13'h1FFF}, "R2 lsb differs");
    lookup({key_of(2) ^ 16'h8000, 3'd0, 13'h0}, "R2 msb differs");
    // R1 stride passes through on miss and hit, all stride codes
    for (int st = 0; st < 8; st++) lookup({key_of(st % 2 == 0 ? 1 : 9), 3'(st), 13'h0AAA}, "R1 stride");

    // R3 duplicate key in slots 3 and 9, lowest slot wins
    twrite(9, key_of(3), 15'h7001, 16'hBEEF, 1'b1);
    lookup({key_of(3), 3'd2, 13'h0}, "R3 lowest slot wins");
    // R5 empty slot 3: slot 9 now answers
    twrite(3, 16'h0000, 15'h0, 16'h0, 1'b0);
    lookup({key_of(3), 3'd2, 13'h0}, "R5 emptied slot skipped");
    // R5 refill slot 3 with the same key: its row came back updated
    twrite(3, key_of(3), 15'h0333, 16'h3333, 1'b1);
    lookup({key_of(3), 3'd4, 13'h0}, "R3 refilled lower slot wins");

    // R6 store a new key on the lookup's edge: lookup misses, next one hits
    lookup_with_write({16'h5A5A, 3'd3, 13'h0}, 12, 16'h5A5A, 15'h4242, 16'hC0DE, 1'b1,
                      "R6 same-edge store not seen");
    lookup({16'h5A5A, 3'd3, 13'h0}, "R6 store seen next");
    // R6 empty a slot on the lookup's edge: lookup still hits with old row
    lookup_with_write({16'h5A5A, 3'd6, 13'h0}, 12, 16'h0, 15'h0, 16'h0, 1'b0,
                      "R6 same-edge empty not seen");
    lookup({16'h5A5A, 3'd6, 13'h0}, "R6 empty seen next");
    // R5 row kept after emptying: refill slot 12 key only check via fresh store
    drain();

    // R7 back-to-back lookups without stalls
    for (int i = 0; i < 10; i++) lookup({key_of(i % 7), 3'(i), 13'h0}, "R7 streaming");

    // R8 random stalls on res_ready
    bp_on = 1'b1;
    for (int i = 0; i < 60; i++)
      lookup({(($urandom % 2) != 0) ? key_of($urandom % 10) : 16'($urandom), 3'($urandom), 13'h0},
             "R8 under back-pressure");
    bp_on = 1'b0;
    drain();
    check(exp_q.size() == 0, "R8 all results returned", 64'(exp_q.size()), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule